// File: doc/BRIEF.md
# MII Carrier Sense and Collision Generator

This block produces the carrier and collision indications that a Fast Ethernet physical-layer device presents to its MAC over the MII, and frames the receive valid and receive error strobes. It watches the MAC's transmit enable and transmit error lines, together with three inputs from the receive datapath: an activity flag, a start-of-frame strobe and an end-of-stream strobe. A duplex select and a node/repeater select choose where carrier sense is sourced from. The block also tells the transmit encoder which nibbles must be replaced with invalid code groups.

Every output is a registered function of the inputs. The decision is taken in the MII clock cycle in which the inputs are presented and shows up one clock later, so it lines up with a datapath that holds each nibble in a register for one stage. The duplex and repeater selects act directly on the output logic and have no pipeline delay.

Top module: `mii_carrier_sense`

## Requirements
- R1: In half duplex with repeater mode off, `crs_o` equals the OR of `tx_en_i` and `rx_act_i` from the previous clock.
- R2: In full duplex (`full_dup_i`=1), `crs_o` equals `rx_act_i` from the previous clock, whatever `tx_en_i` does.
- R3: In repeater mode (`rptr_mode_i`=1) with half duplex, `crs_o` equals `rx_act_i` from the previous clock, whatever `tx_en_i` does.
- R4: In half duplex, `col_o` is high exactly when `tx_en_i` and `rx_act_i` were both high in the previous clock. This holds in node mode and in repeater mode.
- R5: In full duplex, `col_o` stays low even when transmit and receive activity overlap.
- R6: `tx_bad_o` is high exactly when `tx_en_i` and `tx_er_i` were both high in the previous clock. `tx_er_i` without `tx_en_i` has no effect.
- R7: With no frame in progress, `rx_sfd_i` and `rx_act_i` high together raise `rx_dv_o` on the next clock. `rx_sfd_i` without `rx_act_i` has no effect.
- R8: `rx_eos_i` during a frame drops `rx_dv_o` on the next clock. `rx_dv_o` then stays low, and later `rx_sfd_i` strobes are ignored, until `rx_act_i` has been low for at least one clock.
- R9: `rx_act_i` going low during a frame drops `rx_dv_o` on the next clock.
- R10: `rx_er_o` is high on the clock after `rx_err_i` is high, but only if `rx_dv_o` is high in that same later clock. `rx_err_i` outside a frame, or in the cycle of `rx_eos_i`, has no effect.
- R11: While `rst_n` is low and on the first clock after it is released, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MII clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_dup_i | input | 1 | 1 selects full duplex |
| rptr_mode_i | input | 1 | 1 selects repeater mode |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| tx_er_i | input | 1 | Transmit error request from the MAC |
| rx_act_i | input | 1 | Receive medium non-idle, from the receive datapath |
| rx_sfd_i | input | 1 | Start-of-frame delimiter strobe |
| rx_eos_i | input | 1 | End-of-stream delimiter strobe |
| rx_err_i | input | 1 | Receive error detected in the current nibble |
| crs_o | output | 1 | Carrier sense |
| col_o | output | 1 | Collision |
| tx_bad_o | output | 1 | Replace the current transmit nibble with an invalid code |
| rx_dv_o | output | 1 | Receive data valid |
| rx_er_o | output | 1 | Receive error |

## Verification
Suppose an activity register is stuck or stale. Then carrier or collision is wrong at the ports on the very next clock, in whichever duplex and repeater setting exposes that register. Suppose instead the framer state is wrong, for example it never enters its wait-for-idle state after an end-of-stream. Then valid is re-raised by a later start strobe within the same carrier event, and receive errors that belong to no frame leak out. Both show one clock after the stimulus that should have been ignored. The bench drives sequences that reach each of these points and compares every output on every clock.

// File: rtl/mii_cs_pkg.sv
package mii_cs_pkg;

  typedef enum logic [1:0] {
    RXF_IDLE = 2'd0,
    RXF_DATA = 2'd1,
    RXF_TAIL = 2'd2
  } rxf_state_t;

  function automatic logic crs_of(input logic tx_act, input logic rx_act,
                                  input logic fdx, input logic rptr);
    logic rx_only;
    rx_only = fdx | rptr;
    return rx_only ? rx_act : (tx_act | rx_act);
  endfunction

  function automatic logic col_of(input logic tx_act, input logic rx_act,
                                  input logic fdx);
    return (!fdx) & tx_act & rx_act;
  endfunction

  function automatic rxf_state_t rxf_next(input rxf_state_t cur, input logic act,
                                          input logic sfd, input logic eos);
    rxf_state_t n;
    n = cur;
    case (cur)
      RXF_IDLE: if (act && sfd) n = RXF_DATA;
      RXF_DATA: if (!act) n = RXF_IDLE;
                else if (eos) n = RXF_TAIL;
      RXF_TAIL: if (!act) n = RXF_IDLE;
      default:  n = RXF_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/mii_act_reg.sv
module mii_act_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en_i,
  input  logic tx_er_i,
  input  logic rx_act_i,
  output logic tx_act_q,
  output logic rx_act_q,
  output logic tx_bad_q
);

  logic tx_bad_d;
  assign tx_bad_d = tx_en_i & tx_er_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_act_q <= 1'b0;
      rx_act_q <= 1'b0;
      tx_bad_q <= 1'b0;
    end else begin
      tx_act_q <= tx_en_i;
      rx_act_q <= rx_act_i;
      tx_bad_q <= tx_bad_d;
    end
  end

  // R6: a marked nibble always belongs to an active transmission
  p_bad_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bad_q |-> tx_act_q);

  // R6: error request without enable leaves no mark
  p_er_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_er_i && !tx_en_i) |=> !tx_bad_q);

endmodule

// File: rtl/mii_crs_col.sv
module mii_crs_col
  import mii_cs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_act_q,
  input  logic rx_act_q,
  input  logic full_dup_i,
  input  logic rptr_mode_i,
  output logic crs_o,
  output logic col_o
);

  assign crs_o = crs_of(tx_act_q, rx_act_q, full_dup_i, rptr_mode_i);
  assign col_o = col_of(tx_act_q, rx_act_q, full_dup_i);

  // R4: a collision is always accompanied by carrier
  p_col_has_crs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    col_o |-> crs_o);

  // R5: no collision while full duplex is selected
  p_no_col_fdx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full_dup_i && $past(full_dup_i)) |-> !col_o);

endmodule

// File: rtl/mii_rx_framer.sv
module mii_rx_framer
  import mii_cs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_act_i,
  input  logic rx_sfd_i,
  input  logic rx_eos_i,
  input  logic rx_err_i,
  output logic rx_dv_o,
  output logic rx_er_o
);

  rxf_state_t st_q, st_d;
  logic       er_q;
  logic       in_frame_next;

  assign st_d          = rxf_next(st_q, rx_act_i, rx_sfd_i, rx_eos_i);
  assign in_frame_next = (st_d == RXF_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= RXF_IDLE;
      er_q <= 1'b0;
    end else begin
      st_q <= st_d;
      er_q <= rx_err_i & in_frame_next;
    end
  end

  assign rx_dv_o = (st_q == RXF_DATA);
  assign rx_er_o = er_q;

  // R10: errors are only reported inside a valid frame
  p_er_in_dv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_er_o |-> rx_dv_o);

  // R8: end-of-stream closes the frame on the next clock
  p_eos_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eos_i |=> !rx_dv_o);

  // R9: loss of activity closes the frame on the next clock
  p_act_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_act_i |=> !rx_dv_o);

  // R7: valid only opens after a start strobe
  p_open_on_sfd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv_o) |-> ($past(rx_sfd_i) && $past(rx_act_i)));

endmodule

// File: rtl/mii_carrier_sense.sv
module mii_carrier_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic full_dup_i,
  input  logic rptr_mode_i,
  input  logic tx_en_i,
  input  logic tx_er_i,
  input  logic rx_act_i,
  input  logic rx_sfd_i,
  input  logic rx_eos_i,
  input  logic rx_err_i,
  output logic crs_o,
  output logic col_o,
  output logic tx_bad_o,
  output logic rx_dv_o,
  output logic rx_er_o
);

  logic tx_act_q;
  logic rx_act_q;

  mii_act_reg u_act (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en_i  (tx_en_i),
    .tx_er_i  (tx_er_i),
    .rx_act_i (rx_act_i),
    .tx_act_q (tx_act_q),
    .rx_act_q (rx_act_q),
    .tx_bad_q (tx_bad_o)
  );

  mii_crs_col u_crs (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_act_q    (tx_act_q),
    .rx_act_q    (rx_act_q),
    .full_dup_i  (full_dup_i),
    .rptr_mode_i (rptr_mode_i),
    .crs_o       (crs_o),
    .col_o       (col_o)
  );

  mii_rx_framer u_rxf (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_act_i (rx_act_i),
    .rx_sfd_i (rx_sfd_i),
    .rx_eos_i (rx_eos_i),
    .rx_err_i (rx_err_i),
    .rx_dv_o  (rx_dv_o),
    .rx_er_o  (rx_er_o)
  );

  // R2: in full duplex an idle receiver means no carrier next clock
  p_fdx_rx_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full_dup_i && !$past(rx_act_i)) |-> !crs_o);

  // R3: in repeater mode transmit alone never raises carrier
  p_rptr_rx_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rptr_mode_i && !$past(rx_act_i)) |-> !crs_o);

  // R1: half-duplex node carrier follows transmit as well
  p_hdx_tx_crs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_dup_i && !rptr_mode_i && $past(tx_en_i) && $past(rst_n)) |-> crs_o);

endmodule

// File: tb/mii_carrier_sense_test.sv
`timescale 1ns/1ps
module mii_carrier_sense_test;

  typedef struct packed {
    logic crs, col, bad, dv, er;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic full_dup_i = 1'b0, rptr_mode_i = 1'b0;
  logic tx_en_i = 1'b0, tx_er_i = 1'b0, rx_act_i = 1'b0;
  logic rx_sfd_i = 1'b0, rx_eos_i = 1'b0, rx_err_i = 1'b0;
  logic crs_o, col_o, tx_bad_o, rx_dv_o, rx_er_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  exp_t sb_q[$];

  // bench receive model: open frame / waiting for idle
  bit m_open = 0;
  bit m_wait = 0;

  always #5 clk = ~clk;

  mii_carrier_sense uut (
    .clk(clk), .rst_n(rst_n), .full_dup_i(full_dup_i), .rptr_mode_i(rptr_mode_i),
    .tx_en_i(tx_en_i), .tx_er_i(tx_er_i), .rx_act_i(rx_act_i),
    .rx_sfd_i(rx_sfd_i), .rx_eos_i(rx_eos_i), .rx_err_i(rx_err_i),
    .crs_o(crs_o), .col_o(col_o), .tx_bad_o(tx_bad_o),
    .rx_dv_o(rx_dv_o), .rx_er_o(rx_er_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: one clock of stimulus, expected outputs pushed to the scoreboard
  task automatic step(input logic fd, input logic rp, input logic te, input logic tr,
                      input logic ra, input logic sf, input logic eo, input logic ee);
    exp_t e;
    bit was_open;
    @(negedge clk);
    full_dup_i = fd; rptr_mode_i = rp; tx_en_i = te; tx_er_i = tr;
    rx_act_i = ra; rx_sfd_i = sf; rx_eos_i = eo; rx_err_i = ee;
    if (fd) e.crs = ra;
    else if (rp) e.crs = ra;
    else e.crs = te | ra;
    e.col = (fd == 1'b0) && te && ra;
    e.bad = te && tr;
    was_open = m_open;
    if (!ra) begin
      m_open = 0; m_wait = 0;
    end else if (was_open && eo) begin
      m_open = 0; m_wait = 1;
    end else if (!was_open && !m_wait && sf) begin
      m_open = 1;
    end
    e.dv = m_open;
    e.er = m_open && ee;
    sb_q.push_back(e);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(full_dup_i ? "R2 crs" : (rptr_mode_i ? "R3 crs" : "R1 crs"), crs_o, e.crs);
        chk(full_dup_i ? "R5 col" : "R4 col", col_o, e.col);
        chk("R6 tx_bad", tx_bad_o, e.bad);
        chk("R7/R8/R9 rx_dv", rx_dv_o, e.dv);
        chk("R10 rx_er", rx_er_o, e.er);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11: reset state, with activity present on the inputs
    @(negedge clk);
    tx_en_i = 1; rx_act_i = 1; rx_sfd_i = 1; tx_er_i = 1;
    repeat (3) @(negedge clk);
    chk("R11 crs", crs_o, 1'b0); chk("R11 col", col_o, 1'b0);
    chk("R11 bad", tx_bad_o, 1'b0); chk("R11 dv", rx_dv_o, 1'b0);
    tx_en_i = 0; rx_act_i = 0; rx_sfd_i = 0; tx_er_i = 0;
    rst_n = 1;
    @(negedge clk);
    chk("R11 first clock crs", crs_o, 1'b0);
    chk("R11 first clock er", rx_er_o, 1'b0);

    // R1/R4: half duplex node: tx only, rx only, overlap
    step(0,0,1,0,0,0,0,0); step(0,0,1,0,0,0,0,0); step(0,0,0,0,0,0,0,0);
    step(0,0,0,0,1,0,0,0); step(0,0,1,0,1,0,0,0); step(0,0,1,0,1,0,0,0);
    step(0,0,0,0,0,0,0,0);
    // R2/R5: full duplex overlap
    step(1,0,1,0,0,0,0,0); step(1,0,1,0,1,0,0,0); step(1,0,0,0,1,0,0,0);
    step(1,0,0,0,0,0,0,0);
    // R3/R4: repeater half duplex
    step(0,1,1,0,0,0,0,0); step(0,1,1,0,1,0,0,0); step(0,1,0,0,1,0,0,0);
    step(0,1,0,0,0,0,0,0);
    // R6: error request with and without enable
    step(0,0,0,1,0,0,0,0); step(0,0,1,1,0,0,0,0); step(0,0,1,0,0,0,0,0);
    step(0,0,1,1,0,0,0,0); step(0,0,0,0,0,0,0,0);
    // R7: sfd without activity ignored, then a real frame with error inside (R10)
    step(0,0,0,0,0,1,0,1); step(0,0,0,0,1,0,0,1); step(0,0,0,0,1,1,0,0);
    step(0,0,0,0,1,0,0,0); step(0,0,0,0,1,0,0,1); step(0,0,0,0,1,0,0,0);
    // R8: eos with error in same cycle, then sfd ignored while carrier stays
    step(0,0,0,0,1,0,1,1); step(0,0,0,0,1,1,0,1); step(0,0,0,0,1,0,0,0);
    step(0,0,0,0,0,0,0,0);
    // new frame after idle, dropped by activity loss (R9)
    step(0,0,0,0,1,1,0,0); step(0,0,0,0,1,0,0,0); step(0,0,0,0,0,0,0,1);
    step(0,0,0,0,1,1,0,0); step(1,0,1,0,1,0,0,1); step(1,0,0,0,1,0,1,0);
    step(0,0,0,0,0,0,0,0); step(0,0,0,0,0,0,0,0);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule